// File: doc/BRIEF.md
# Quad Wiper Register Command Executor

This block is the register and command core of a four-channel digital potentiometer. Each channel keeps one wiper position register, whose value sets the tap, and four stored preset registers. A serial front end, outside this block, deserializes the bus and hands over whole bytes, single bits, and strobes that mark the start and the end of a frame. The first byte of a frame is a command. It carries a 4-bit operation code in bits 7:4, a 2-bit preset select in bits 3:2 and a 2-bit channel select in bits 1:0. The block decodes that byte and then performs the operation. The operations are register reads and writes, copies between a preset and its wiper in either direction, copies that act on all four channels in the same clock, and a streamed step mode in which each incoming bit moves one wiper up or down by one tap.

Register values are `VAL_W` bits wide (6 by default, 64 taps). Read results come back as a byte on a one-cycle valid pulse. Any store into a preset register starts a modelled nonvolatile write cycle that lasts `WIP_CYCLES` clocks. While that cycle runs, further preset stores are refused, and a status command reports the busy flag. The four wiper positions are presented continuously on a flat output bus.

Top module: `quadpot_cmd_core`

## Requirements
- R1: Command 1001_00pp (pp = channel, bits 1:0) returns that channel's wiper value: rd_valid pulses one cycle after the command byte, rd_data carries the value in its low VAL_W bits, and bits above VAL_W are zero.
- R2: Command 1010_00pp followed by a data byte loads the data's low VAL_W bits into wiper pp. The upper data bits are ignored, and wiper_out shows the new value one cycle after the data byte.
- R3: Command 1100_rrpp (rr = preset, bits 3:2) followed by a data byte stores its low VAL_W bits into preset rr of channel pp. Command 1011_rrpp reads that preset back in the same way as R1.
- R4: Command 1101_rrpp copies preset rr of channel pp into wiper pp. Command 1110_rrpp copies wiper pp into preset rr of channel pp.
- R5: Command 0001_rr00 loads every channel's wiper from that channel's preset rr in the same cycle. With bits 1:0 not 00, the command does nothing.
- R6: Command 1000_rr00 stores every channel's wiper into that channel's preset rr in the same cycle. With bits 1:0 not 00, the command does nothing.
- R7: After command 0010_00pp, each bit strobe raises wiper pp by one when the bit is 1 and lowers it by one when the bit is 0. The wiper saturates at 0 and at 2^VAL_W-1. Byte strobes have no effect in this mode, and the mode lasts until the frame ends.
- R8: Every accepted preset store (R3 write, R4 copy to a preset, R6) sets the busy flag for exactly WIP_CYCLES clocks. Command 0101_0001 returns the busy flag in rd_data bit 0, and the other bits read as zero.
- R9: While the busy flag is set, preset stores (1100, 1110, 1000) are discarded. Wiper writes and copies into wipers are still carried out.
- R10: An undefined opcode, or a command with nonzero bits in a field that must be zero (bits 3:2 of 1001, 1010 and 0010, bits 1:0 of 0001 and 1000, the low nibble of 0101 other than 0001), changes no register and produces no read.
- R11: Only the first byte after frame_start is decoded as a command. A write takes exactly one data byte, and any later bytes or bits in the frame are ignored, as are bytes and bits outside a frame. frame_end takes priority over frame_start, and a byte or bit in the same cycle as either strobe is dropped.
- R12: After reset all wipers and presets are zero, rd_valid is low and the busy flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle strobe: a frame begins |
| frame_end | input | 1 | One-cycle strobe: the frame ends |
| byte_valid | input | 1 | One-cycle strobe: byte_data holds a received byte |
| byte_data | input | 8 | Received command or data byte |
| bit_valid | input | 1 | One-cycle strobe: bit_data holds a received bit |
| bit_data | input | 1 | Step direction bit, 1 = up, 0 = down |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a read result |
| rd_data | output | 8 | Read result byte, zero when rd_valid is low |
| wiper_out | output | 4*VAL_W | Wiper positions, channel n at bits n*VAL_W upward |

## Verification
Every result of this block is registered once. A wiper or preset change is due on the rising edge that samples the strobe that caused it. A read result is due on the rising edge that samples the command byte, and appears as a single rd_valid cycle. The busy flag rises on the edge that accepts a preset store and stays high for exactly WIP_CYCLES edges. The bench advances its behavioural model on the same rising edge as the design and compares wiper_out, rd_valid and rd_data at the following falling edge, so each result is checked in the cycle it is due and in no other.

// File: rtl/qp_pkg.sv
// Shared definitions for the quad wiper command core.
// Assumes the command byte layout: opcode in bits 7:4, preset
// select in bits 3:2, channel select in bits 1:0.
package qp_pkg;
    localparam int BYTE_W = 8;
    localparam int OP_W   = 4;
    localparam int SEL_W  = 2;

    localparam logic [OP_W-1:0] OPC_ALL_LOAD  = 4'b0001;
    localparam logic [OP_W-1:0] OPC_STEP      = 4'b0010;
    localparam logic [OP_W-1:0] OPC_STATUS    = 4'b0101;
    localparam logic [OP_W-1:0] OPC_ALL_STORE = 4'b1000;
    localparam logic [OP_W-1:0] OPC_WPR_RD    = 4'b1001;
    localparam logic [OP_W-1:0] OPC_WPR_WR    = 4'b1010;
    localparam logic [OP_W-1:0] OPC_PRE_RD    = 4'b1011;
    localparam logic [OP_W-1:0] OPC_PRE_WR    = 4'b1100;
    localparam logic [OP_W-1:0] OPC_PRE2WPR   = 4'b1101;
    localparam logic [OP_W-1:0] OPC_WPR2PRE   = 4'b1110;

    // Decoded operation of one command byte
    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_WPR_RD,
        ACT_WPR_WR,
        ACT_PRE_RD,
        ACT_PRE_WR,
        ACT_PRE2WPR,
        ACT_WPR2PRE,
        ACT_ALL_LOAD,
        ACT_ALL_STORE,
        ACT_STEP,
        ACT_STATUS
    } act_e;

    typedef struct packed {
        act_e             act;
        logic [SEL_W-1:0] pre_sel;
        logic [SEL_W-1:0] ch_sel;
    } cmd_t;

    // Position within a frame
    typedef enum logic [2:0] {
        FR_IDLE,
        FR_CMD,
        FR_DATA,
        FR_STEP,
        FR_DONE
    } frame_e;
endpackage

// File: rtl/qp_cmd_decode.sv
// Purely combinational command decoder.
// Maps a command byte to an operation plus its selects. Any opcode
// that is undefined, or any defined opcode with a must-be-zero field
// that is not zero, decodes to ACT_NONE.
module qp_cmd_decode
    import qp_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_t              cmd
);
    logic [OP_W-1:0]  op;
    logic [SEL_W-1:0] pre_f;
    logic [SEL_W-1:0] ch_f;

    assign op    = cmd_byte[7:4];
    assign pre_f = cmd_byte[3:2];
    assign ch_f  = cmd_byte[1:0];

    // Classify the opcode and check its reserved fields
    always_comb begin
        cmd.act     = ACT_NONE;
        cmd.pre_sel = pre_f;
        cmd.ch_sel  = ch_f;
        case (op)
            OPC_WPR_RD:    if (pre_f == '0) cmd.act = ACT_WPR_RD;
            OPC_WPR_WR:    if (pre_f == '0) cmd.act = ACT_WPR_WR;
            OPC_PRE_RD:    cmd.act = ACT_PRE_RD;
            OPC_PRE_WR:    cmd.act = ACT_PRE_WR;
            OPC_PRE2WPR:   cmd.act = ACT_PRE2WPR;
            OPC_WPR2PRE:   cmd.act = ACT_WPR2PRE;
            OPC_ALL_LOAD:  if (ch_f == '0) cmd.act = ACT_ALL_LOAD;
            OPC_ALL_STORE: if (ch_f == '0) cmd.act = ACT_ALL_STORE;
            OPC_STEP:      if (pre_f == '0) cmd.act = ACT_STEP;
            OPC_STATUS:    if (cmd_byte[3:0] == 4'b0001) cmd.act = ACT_STATUS;
            default:       cmd.act = ACT_NONE;
        endcase
    end
endmodule

// File: rtl/qp_wip_timer.sv
// Write-in-progress timer.
// A start pulse loads the counter with CYCLES and busy stays high
// until the counter has run down to zero, which takes exactly CYCLES
// clocks. Assumes start is raised only while busy is low.
module qp_wip_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/qp_regfile.sv
// Wiper and preset storage for NPOT channels.
// Every channel owns one wiper register and NREG presets. One command
// acts per cycle, so the update enables are mutually exclusive. The
// all-channel load and store use all_reg as the preset index of every
// channel. Stepping saturates at zero and at the largest value.
module qp_regfile #(
    parameter int VAL_W = 6,
    parameter int NPOT  = 4,
    parameter int NREG  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(NPOT)-1:0]    sel_ch,
    input  logic [$clog2(NREG)-1:0]    sel_pre,
    input  logic                       wpr_we,
    input  logic [VAL_W-1:0]           wpr_wval,
    input  logic                       step_en,
    input  logic                       step_up,
    input  logic                       all_load,
    input  logic                       all_store,
    input  logic                       pre_we,
    input  logic [VAL_W-1:0]           pre_wval,
    output logic [NPOT-1:0][VAL_W-1:0] wpr_q,
    output logic [VAL_W-1:0]           sel_wpr,
    output logic [VAL_W-1:0]           sel_pre_val
);
    localparam int PW = $clog2(NPOT);
    localparam int RW = $clog2(NREG);
    localparam logic [VAL_W-1:0] VMAX = '1;

    logic [NPOT-1:0][NREG-1:0][VAL_W-1:0] pre_q;

    for (genvar p = 0; p < NPOT; p++) begin : g_ch
        logic ch_hit;
        assign ch_hit = (sel_ch == PW'(p));

        // Wiper update: all-channel load, direct write, or one step
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wpr_q[p] <= '0;
            end else if (all_load) begin
                wpr_q[p] <= pre_q[p][sel_pre];
            end else if (wpr_we && ch_hit) begin
                wpr_q[p] <= wpr_wval;
            end else if (step_en && ch_hit) begin
                if (step_up) begin
                    if (wpr_q[p] != VMAX) wpr_q[p] <= wpr_q[p] + 1'b1;
                end else begin
                    if (wpr_q[p] != '0) wpr_q[p] <= wpr_q[p] - 1'b1;
                end
            end
        end

        for (genvar r = 0; r < NREG; r++) begin : g_pre
            logic pre_hit;
            assign pre_hit = (sel_pre == RW'(r));

            // Preset update: all-channel store or single store
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q[p][r] <= '0;
                end else if (all_store && pre_hit) begin
                    pre_q[p][r] <= wpr_q[p];
                end else if (pre_we && ch_hit && pre_hit) begin
                    pre_q[p][r] <= pre_wval;
                end
            end
        end
    end

    assign sel_wpr     = wpr_q[sel_ch];
    assign sel_pre_val = pre_q[sel_ch][sel_pre];
endmodule

// File: rtl/quadpot_cmd_core.sv
// Command executor for a four-channel wiper register set.
// Takes frame strobes plus deserialized bytes and bits, decodes the
// first byte of each frame as a command and carries it out. Read
// results are registered and appear one cycle after the command byte.
// Assumes strobes last one cycle. Frame end wins over frame start, and
// a byte or bit arriving together with either strobe is dropped.
module quadpot_cmd_core
    import qp_pkg::*;
#(
    parameter int VAL_W      = 6,
    parameter int WIP_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic                  frame_end,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_data,
    input  logic                  bit_valid,
    input  logic                  bit_data,
    output logic                  rd_valid,
    output logic [7:0]            rd_data,
    output logic [4*VAL_W-1:0]    wiper_out
);
    localparam int NPOT = 1 << SEL_W;
    localparam int NREG = 1 << SEL_W;

    frame_e           state_q, state_d;
    cmd_t             pend_q, pend_d;
    cmd_t             dec_cmd;
    logic [SEL_W-1:0] sel_ch, sel_pre;
    logic             wpr_we, step_en, all_load, all_store, pre_we;
    logic [VAL_W-1:0] wpr_wval, pre_wval, sel_wpr, sel_pre_val;
    logic             wip_busy, wip_start;
    logic             rv_d;
    logic [7:0]       rd_d;
    logic [NPOT-1:0][VAL_W-1:0] wpr_q;

    qp_cmd_decode u_dec (
        .cmd_byte (byte_data),
        .cmd      (dec_cmd)
    );

    // Selects come from the live byte while decoding, else from the held command
    assign sel_ch  = (state_q == FR_CMD) ? dec_cmd.ch_sel  : pend_q.ch_sel;
    assign sel_pre = (state_q == FR_CMD) ? dec_cmd.pre_sel : pend_q.pre_sel;

    // Frame sequencing and per-command action strobes
    always_comb begin
        state_d   = state_q;
        pend_d    = pend_q;
        wpr_we    = 1'b0;
        wpr_wval  = byte_data[VAL_W-1:0];
        step_en   = 1'b0;
        all_load  = 1'b0;
        all_store = 1'b0;
        pre_we    = 1'b0;
        pre_wval  = byte_data[VAL_W-1:0];
        rv_d      = 1'b0;
        rd_d      = '0;
        if (frame_end) begin
            state_d = FR_IDLE;
        end else if (frame_start) begin
            state_d = FR_CMD;
        end else begin
            case (state_q)
                FR_CMD: if (byte_valid) begin
                    state_d = FR_DONE;
                    pend_d  = dec_cmd;
                    case (dec_cmd.act)
                        ACT_WPR_RD: begin
                            rv_d = 1'b1;
                            rd_d = BYTE_W'(sel_wpr);
                        end
                        ACT_PRE_RD: begin
                            rv_d = 1'b1;
                            rd_d = BYTE_W'(sel_pre_val);
                        end
                        ACT_STATUS: begin
                            rv_d = 1'b1;
                            rd_d = BYTE_W'(wip_busy);
                        end
                        ACT_WPR_WR, ACT_PRE_WR: state_d = FR_DATA;
                        ACT_PRE2WPR: begin
                            wpr_we   = 1'b1;
                            wpr_wval = sel_pre_val;
                        end
                        ACT_WPR2PRE: begin
                            pre_we   = !wip_busy;
                            pre_wval = sel_wpr;
                        end
                        ACT_ALL_LOAD:  all_load  = 1'b1;
                        ACT_ALL_STORE: all_store = !wip_busy;
                        ACT_STEP:      state_d   = FR_STEP;
                        default:       state_d   = FR_DONE;
                    endcase
                end
                FR_DATA: if (byte_valid) begin
                    state_d = FR_DONE;
                    if (pend_q.act == ACT_WPR_WR) begin
                        wpr_we = 1'b1;
                    end else begin
                        pre_we = !wip_busy;
                    end
                end
                FR_STEP: step_en = bit_valid;
                default: state_d = state_q;
            endcase
        end
    end

    assign wip_start = pre_we | all_store;

    // Frame state and held command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            pend_q  <= '{act: ACT_NONE, pre_sel: '0, ch_sel: '0};
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // Registered read result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rv_d;
            rd_data  <= rd_d;
        end
    end

    qp_regfile #(
        .VAL_W (VAL_W),
        .NPOT  (NPOT),
        .NREG  (NREG)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_ch      (sel_ch),
        .sel_pre     (sel_pre),
        .wpr_we      (wpr_we),
        .wpr_wval    (wpr_wval),
        .step_en     (step_en),
        .step_up     (bit_data),
        .all_load    (all_load),
        .all_store   (all_store),
        .pre_we      (pre_we),
        .pre_wval    (pre_wval),
        .wpr_q       (wpr_q),
        .sel_wpr     (sel_wpr),
        .sel_pre_val (sel_pre_val)
    );

    qp_wip_timer #(
        .CYCLES (WIP_CYCLES)
    ) u_wip (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wip_start),
        .busy  (wip_busy)
    );

    assign wiper_out = wpr_q;
endmodule

// File: rtl/qp_checker.sv
// Property checker for quadpot_cmd_core, attached with bind.
// Observes the ports and the write-in-progress flag only.
module qp_checker #(
    parameter int VAL_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic               frame_end,
    input logic               byte_valid,
    input logic               bit_valid,
    input logic               rd_valid,
    input logic [7:0]         rd_data,
    input logic [4*VAL_W-1:0] wiper_out,
    input logic               wip_busy
);
    AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data >> VAL_W) == 8'd0)); // R1

    AST_RD_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(byte_valid) && !$past(frame_start) && !$past(frame_end))); // R11

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == 8'd0)); // R1

    AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(byte_valid) && !$past(bit_valid)) |-> $stable(wiper_out)); // R2

    AST_WIP_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip_busy) |-> $past(byte_valid)); // R8

    for (genvar p = 0; p < 4; p++) begin : g_step
        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bit_valid) && !$past(byte_valid)) |->
                ((wiper_out[p*VAL_W +: VAL_W] == $past(wiper_out[p*VAL_W +: VAL_W])) ||
                 (wiper_out[p*VAL_W +: VAL_W] == $past(wiper_out[p*VAL_W +: VAL_W]) + 1'b1) ||
                 (wiper_out[p*VAL_W +: VAL_W] == $past(wiper_out[p*VAL_W +: VAL_W]) - 1'b1))); // R7
    end
endmodule

bind quadpot_cmd_core qp_checker #(.VAL_W(VAL_W)) u_qp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .byte_valid  (byte_valid),
    .bit_valid   (bit_valid),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .wiper_out   (wiper_out),
    .wip_busy    (wip_busy)
);

// File: tb/quadpot_cmd_core_bench.sv
// Bench: a behavioural model advances on each rising edge, and the
// design's outputs are compared against it on each falling edge.
module quadpot_cmd_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VW   = 6;
    localparam int WIPN = 16;
    localparam int VMAX = (1 << VW) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0, frame_end = 1'b0;
    logic       byte_valid = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
    logic [7:0] byte_data = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [4*VW-1:0] wiper_out;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R12";
    bit    checking = 1'b0;

    // Model state
    int m_w [4];
    int m_d [4][4];
    int m_wip, m_st, m_op, m_pr, m_pp, m_busy, m_start;
    int e_rv, e_rd;
    int op, rr, pp, vv;

    quadpot_cmd_core #(.VAL_W(VW), .WIP_CYCLES(WIPN)) u_quadpot_cmd_core (
        .clk (clk), .rst_n (rst_n),
        .frame_start (frame_start), .frame_end (frame_end),
        .byte_valid (byte_valid), .byte_data (byte_data),
        .bit_valid (bit_valid), .bit_data (bit_data),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .wiper_out (wiper_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: states 0 idle, 1 command, 2 data, 3 step, 4 done
    always @(posedge clk) begin
        e_rv = 0;
        e_rd = 0;
        if (!rst_n) begin
            for (int p = 0; p < 4; p++) begin
                m_w[p] = 0;
                for (int r = 0; r < 4; r++) m_d[p][r] = 0;
            end
            m_wip = 0; m_st = 0; m_op = 0; m_pr = 0; m_pp = 0;
        end else begin
            m_busy  = (m_wip != 0);
            m_start = 0;
            op = byte_data[7:4]; rr = byte_data[3:2]; pp = byte_data[1:0];
            vv = byte_data & VMAX;
            if (frame_end) m_st = 0;
            else if (frame_start) m_st = 1;
            else if (byte_valid && m_st == 1) begin
                m_st = 4;
                if (op == 9 && rr == 0) begin e_rv = 1; e_rd = m_w[pp]; end
                else if (op == 10 && rr == 0) begin m_st = 2; m_op = 10; m_pp = pp; end
                else if (op == 11) begin e_rv = 1; e_rd = m_d[pp][rr]; end
                else if (op == 12) begin m_st = 2; m_op = 12; m_pp = pp; m_pr = rr; end
                else if (op == 13) m_w[pp] = m_d[pp][rr];
                else if (op == 14) begin
                    if (!m_busy) begin m_d[pp][rr] = m_w[pp]; m_start = 1; end
                end
                else if (op == 1 && pp == 0) begin
                    for (int q = 0; q < 4; q++) m_w[q] = m_d[q][rr];
                end
                else if (op == 8 && pp == 0) begin
                    if (!m_busy) begin
                        for (int q = 0; q < 4; q++) m_d[q][rr] = m_w[q];
                        m_start = 1;
                    end
                end
                else if (op == 2 && rr == 0) begin m_st = 3; m_pp = pp; end
                else if (byte_data == 8'h51) begin e_rv = 1; e_rd = m_busy; end
            end else if (byte_valid && m_st == 2) begin
                m_st = 4;
                if (m_op == 10) m_w[m_pp] = vv;
                else if (!m_busy) begin m_d[m_pp][m_pr] = vv; m_start = 1; end
            end else if (bit_valid && m_st == 3) begin
                if (bit_data) begin if (m_w[m_pp] < VMAX) m_w[m_pp]++; end
                else begin if (m_w[m_pp] > 0) m_w[m_pp]--; end
            end
            if (m_start) m_wip = WIPN;
            else if (m_wip > 0) m_wip--;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (checking) begin
            for (int p = 0; p < 4; p++) chk("wiper", int'(wiper_out[p*VW +: VW]), m_w[p]);
            chk("rd_valid", int'(rd_valid), e_rv);
            chk("rd_data", int'(rd_data), e_rd);
        end
    end

    task automatic drive(input logic fs, input logic fe, input logic bv,
                         input logic [7:0] bd, input logic tv, input logic td);
        @(negedge clk);
        frame_start = fs; frame_end = fe; byte_valid = bv;
        byte_data = bd; bit_valid = tv; bit_data = td;
        @(negedge clk);
        frame_start = 1'b0; frame_end = 1'b0; byte_valid = 1'b0;
        byte_data = '0; bit_valid = 1'b0; bit_data = 1'b0;
    endtask

    task automatic fstart();               drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0); endtask
    task automatic fend();                 drive(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0); endtask
    task automatic sbyte(input logic [7:0] b); drive(1'b0, 1'b0, 1'b1, b, 1'b0, 1'b0); endtask
    task automatic sbit(input logic b);     drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, b); endtask
    task automatic frame1(input logic [7:0] c); fstart(); sbyte(c); fend(); endtask
    task automatic frame2(input logic [7:0] c, input logic [7:0] d);
        fstart(); sbyte(c); sbyte(d); fend();
    endtask
    task automatic waitc(input int n); repeat (n) @(negedge clk); endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual %0d expected %0d", 200000, 0);
        finish_run();
    end

    initial begin
        cur_req = "R12";
        repeat (3) @(posedge clk);
        checking = 1'b1;
        waitc(2);
        rst_n = 1'b1;
        waitc(2);

        cur_req = "R2";  frame2(8'hA2, 8'hEA);          // wiper 2 <- 0x2A, top bits dropped
        cur_req = "R1";  frame1(8'h92);                 // read wiper 2
        cur_req = "R3";  frame2(8'hCD, 8'h15);          // preset 3 of ch 1 <- 0x15
        frame1(8'hBD);
        waitc(WIPN + 4);

        cur_req = "R8";  frame2(8'hC0, 8'h33);          // preset 0 of ch 0, starts busy
        frame1(8'h51);                                  // status reads busy = 1
        cur_req = "R9";  frame2(8'hC0, 8'h11);          // refused while busy
        frame2(8'hA1, 8'h07);                           // wiper write still accepted
        frame1(8'hE4);                                  // copy to preset refused
        frame1(8'h88);                                  // all-store refused
        waitc(WIPN + 4);
        cur_req = "R8";  frame1(8'h51);                 // status reads 0
        cur_req = "R9";  frame1(8'hB0);                 // still 0x33
        frame1(8'hB5);                                  // untouched preset 1 ch 1

        cur_req = "R4";  frame1(8'hDD);                 // wiper 1 <- preset 3 of ch 1
        frame1(8'hE6);                                  // preset 1 of ch 2 <- wiper 2
        waitc(WIPN + 2);
        frame1(8'hB6);

        cur_req = "R6";  frame1(8'h88);                 // all wipers -> preset 2
        waitc(WIPN + 2);
        frame1(8'hB8); frame1(8'hBA);
        frame2(8'hA0, 8'h3F); frame2(8'hA3, 8'h01);
        cur_req = "R10"; frame1(8'h19);                 // all-load with bad ch field
        frame1(8'h89);                                  // all-store with bad ch field
        cur_req = "R5";  frame1(8'h18);                 // all wipers <- preset 2
        frame1(8'h14);                                  // all wipers <- preset 1

        cur_req = "R7";  frame2(8'hA3, 8'h3E);
        fstart(); sbyte(8'h23);
        sbit(1'b1); sbit(1'b1); sbit(1'b1);
        sbyte(8'hA3);                                   // byte ignored in step mode
        for (int i = 0; i < 70; i++) sbit(1'b0);
        sbit(1'b1);
        fend();
        sbit(1'b1);                                     // outside the frame: ignored

        cur_req = "R10";
        frame1(8'h00); frame1(8'hF3); frame1(8'h50); frame1(8'h94);
        frame2(8'hA6, 8'h2C); frame2(8'h26, 8'h00);
        frame1(8'h61); frame1(8'h71); frame1(8'h92);

        cur_req = "R11";
        sbyte(8'hA0); sbyte(8'h05);                     // no frame open
        fstart(); sbyte(8'h92); sbyte(8'h92); sbyte(8'hA2); fend();
        frame2(8'hA0, 8'h09); fstart(); sbyte(8'hA0); sbyte(8'h01); sbyte(8'h22); fend();
        drive(1'b1, 1'b0, 1'b1, 8'h90, 1'b0, 1'b0);     // byte with start: dropped
        sbyte(8'h90); fend();
        fstart(); drive(1'b0, 1'b1, 1'b1, 8'h91, 1'b0, 1'b0); sbyte(8'h91);
        drive(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);     // end wins over start
        sbyte(8'h90);
        fstart(); sbyte(8'h90); fend();

        waitc(4);
        finish_run();
    end
endmodule